// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a parameterised group of interrupt request lines, records a rising edge on any of them as a pending flag, and selects the most urgent source that is both pending and enabled. The processor sees three things: a request, the number of the chosen source, and a handler address read from a small per-source vector table. When the processor accepts a request, the source's priority is pushed onto a stack of active levels. A later source can then interrupt the running handler only if it is more urgent in the preemption sense.

A run-time grouping value divides each priority into two parts. The upper bits form the preemption field, which alone decides whether nesting happens. The lower bits form a sub-ordering field, which only ranks sources that are waiting. Software uses one register port to:
- enable sources,
- program priorities and handler addresses,
- read pending flags and clear them by writing ones,
- set the grouping,
- signal that a handler has finished, which pops the active level.

The controller does not clear a pending flag when the request is accepted. A handler that returns without clearing its flag is therefore taken again as soon as the level drops.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A rising edge (low to high between two clock samples) on `irq_in[i]` sets pending bit i. The bit stays set after the line falls. A line that is held high does not set the bit again once it has been cleared.
- R2: Writing to register 0x01 clears every pending bit whose data bit is 1. Bits written 0 are unchanged. A rising edge in the same cycle as a clear leaves the bit set. Register 0x01 reads back the pending bits in bits [N_SRC-1:0].
- R3: A source whose enable bit is 0 (register 0x00, bit i) is never presented on `irq_req`/`irq_id`, even while its pending bit is set.
- R4: With no active level, the enabled pending source with the numerically smallest full priority value is presented. On equal values, the lowest source number wins. Priority i is at register 0x40+i, in bits [PRIO_W-1:0].
- R5: When `irq_req` is 1, `irq_vec` is the vector entry of the presented source. Entry i is at register 0x80+i and resets to VEC_BASE + 4*i.
- R6: A cycle with `irq_ack` high while `irq_req` is high pushes that source's priority as the new active level. A source whose preemption field is not strictly smaller than the active one is then withheld.
- R7: Register 0x02 holds the grouping g, the number of low sub-ordering bits of each priority. Writes above PRIO_W store PRIO_W. A source preempts only when (prio >> g) < (active >> g). Equal preemption fields never nest.
- R8: Any write to register 0x03 pops one active level. Arbitration then resumes against the level below, or against idle. A source still pending is presented again in the next cycle.
- R9: After reset, enables, pending bits, priorities, grouping and stack depth are 0, and `irq_req` is 0.
- R10: Register 0x04 reads the stack depth in bits [7:0] and the top active priority in bits [15:8]. The top priority reads 0 when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Interrupt request lines, edge-detected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address, used for both read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr`, combinational |
| irq_req | output | 1 | A source is being presented to the processor |
| irq_id | output | $clog2(N_SRC) | Number of the presented source, 0 when idle |
| irq_vec | output | DATA_W | Handler address of the presented source, 0 when idle |
| irq_ack | input | 1 | Processor accepts the presented source |

## Verification
The bench goes after the strictness of the nesting test. A pending source whose preemption field equals the active one, but whose full priority is smaller, must stay hidden; a design that compared full priorities or used less-or-equal would nest it. It also changes the grouping while a level is active, writes an out-of-range grouping value, and forces a priority tie. A wrong tie-break would present the higher source number, and a missing clamp would let a grouping of 9 shift away every bit. It also checks that a flag left uncleared is taken again after the level pops, and that a clear and a rising edge in the same cycle leave the flag set. A design that cleared on acceptance, or let the clear win, would lose that request.

// File: rtl/nic_pkg.sv
package nic_pkg;

    // Fixed control register addresses (8-bit register space)
    typedef enum logic [7:0] {
        NIC_REG_ENABLE = 8'h00,
        NIC_REG_PEND   = 8'h01,
        NIC_REG_GROUP  = 8'h02,
        NIC_REG_EOS    = 8'h03,
        NIC_REG_LEVEL  = 8'h04
    } nic_reg_e;

    localparam logic [7:0] NIC_PRIO_BASE = 8'h40;
    localparam logic [7:0] NIC_VEC_BASE  = 8'h80;

    // Stack operation, encoded as {push, pop}
    typedef enum logic [1:0] {
        STK_HOLD = 2'b00,
        STK_POP  = 2'b01,
        STK_PUSH = 2'b10,
        STK_SWAP = 2'b11
    } stk_op_e;

    function automatic int unsigned nic_clamp(input int unsigned val, input int unsigned hi);
        return (val > hi) ? hi : val;
    endfunction

endpackage

// File: rtl/nic_pending.sv
module nic_pending #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_in,
    input  logic [N_SRC-1:0] clr_mask,
    output logic [N_SRC-1:0] pend
);
    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] rise;

    assign rise = irq_in & ~prev_q;
    assign pend = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= irq_in;
            pend_q <= (pend_q & ~clr_mask) | rise;
        end
    end

    // R1: an edge leaves its flag set
    assert_edge_latch_R1: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R2: a clear without a simultaneous edge empties the flag
    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (|(clr_mask & ~rise)) |=> ((pend_q & $past(clr_mask & ~rise)) == '0));

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
    parameter int N_SRC  = 16,
    parameter int PRIO_W = 4,
    localparam int IDW   = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]  cand,
    input  logic [PRIO_W-1:0] prio [N_SRC],
    output logic              best_valid,
    output logic [PRIO_W-1:0] best_prio,
    output logic [IDW-1:0]    best_id
);
    // Ascending scan with a strict compare: on a tie the lower number is kept
    always_comb begin
        best_valid = 1'b0;
        best_prio  = '0;
        best_id    = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand[i] && (!best_valid || (prio[i] < best_prio))) begin
                best_valid = 1'b1;
                best_prio  = prio[i];
                best_id    = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack
    import nic_pkg::*;
#(
    parameter int PRIO_W = 4,
    parameter int DEPTH  = 16,
    localparam int DW    = $clog2(DEPTH + 1),
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_prio,
    output logic [DW-1:0]     depth,
    output logic [PRIO_W-1:0] top_prio,
    output logic              empty,
    output logic              full
);
    logic [PRIO_W-1:0] mem_q [DEPTH];
    logic [DW-1:0]     cnt_q;
    logic [IW-1:0]     wr_idx;
    logic [IW-1:0]     top_idx;
    stk_op_e           op;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == DW'(DEPTH));
    assign depth   = cnt_q;
    assign wr_idx  = IW'(cnt_q);
    assign top_idx = IW'(cnt_q - 1'b1);
    assign top_prio = empty ? '0 : mem_q[top_idx];
    assign op      = stk_op_e'({push && !full, pop && !empty});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            case (op)
                STK_PUSH: begin
                    mem_q[wr_idx] <= push_prio;
                    cnt_q         <= cnt_q + 1'b1;
                end
                STK_POP:  cnt_q <= cnt_q - 1'b1;
                STK_SWAP: mem_q[top_idx] <= push_prio;
                default:  ;
            endcase
        end
    end

    // R6: an accepted push becomes the new top level
    assert_push_top_R6: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (top_prio == $past(push_prio) && depth == $past(depth) + 1'b1));

    // R8: end of service drops exactly one level
    assert_pop_depth_R8: assert property (@(posedge clk) disable iff (rst)
        (pop && !empty && !push) |=> (depth == $past(depth) - 1'b1));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int          N_SRC    = 16,
    parameter int          PRIO_W   = 4,
    parameter int          DATA_W   = 32,
    parameter int unsigned VEC_BASE = 32'h100,
    localparam int         IDW      = $clog2(N_SRC),
    localparam int         DEPTH    = 1 << PRIO_W,
    localparam int         SDW      = $clog2(DEPTH + 1),
    localparam int         GW       = $clog2(PRIO_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [IDW-1:0]    irq_id,
    output logic [DATA_W-1:0] irq_vec,
    input  logic              irq_ack
);
    logic [N_SRC-1:0]  en_q;
    logic [GW-1:0]     grp_q;
    logic [PRIO_W-1:0] prio_q [N_SRC];
    logic [DATA_W-1:0] vec_q  [N_SRC];

    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  clr_mask;
    logic              best_valid;
    logic [PRIO_W-1:0] best_prio;
    logic [IDW-1:0]    best_id;
    logic [SDW-1:0]    stk_depth;
    logic [PRIO_W-1:0] stk_top;
    logic              stk_empty;
    logic              stk_full;
    logic [PRIO_W-1:0] pmask;
    logic              eos_wr;
    logic              can_preempt;

    assign clr_mask = (reg_wr && reg_addr == NIC_REG_PEND) ? reg_wdata[N_SRC-1:0] : '0;
    assign eos_wr   = reg_wr && (reg_addr == NIC_REG_EOS);
    assign pmask    = {PRIO_W{1'b1}} << grp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            grp_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == NIC_REG_ENABLE) en_q <= reg_wdata[N_SRC-1:0];
            if (reg_addr == NIC_REG_GROUP)
                grp_q <= GW'(nic_clamp(32'(reg_wdata), PRIO_W));
        end
    end

    // Per-source priority and vector registers
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q[g] <= '0;
                vec_q[g]  <= DATA_W'(VEC_BASE + 4 * g);
            end else if (reg_wr) begin
                if (reg_addr == NIC_PRIO_BASE + 8'(g)) prio_q[g] <= reg_wdata[PRIO_W-1:0];
                if (reg_addr == NIC_VEC_BASE + 8'(g))  vec_q[g]  <= reg_wdata;
            end
        end
    end

    nic_pending #(.N_SRC(N_SRC)) u_pending (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .clr_mask (clr_mask),
        .pend     (pend)
    );

    nic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arbiter (
        .cand       (pend & en_q),
        .prio       (prio_q),
        .best_valid (best_valid),
        .best_prio  (best_prio),
        .best_id    (best_id)
    );

    nic_level_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (irq_ack && irq_req),
        .pop       (eos_wr),
        .push_prio (best_prio),
        .depth     (stk_depth),
        .top_prio  (stk_top),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    // Only the preemption field takes part in the nesting decision
    assign can_preempt = stk_empty || ((best_prio & pmask) < (stk_top & pmask));
    assign irq_req     = best_valid && can_preempt && !stk_full;
    assign irq_id      = irq_req ? best_id : '0;
    assign irq_vec     = irq_req ? vec_q[best_id] : '0;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            NIC_REG_ENABLE: reg_rdata[N_SRC-1:0] = en_q;
            NIC_REG_PEND:   reg_rdata[N_SRC-1:0] = pend;
            NIC_REG_GROUP:  reg_rdata[GW-1:0]    = grp_q;
            NIC_REG_LEVEL: begin
                reg_rdata[7:0]  = 8'(stk_depth);
                reg_rdata[15:8] = 8'(stk_top);
            end
            default: begin
                for (int i = 0; i < N_SRC; i++) begin
                    if (reg_addr == NIC_PRIO_BASE + 8'(i)) reg_rdata = DATA_W'(prio_q[i]);
                    if (reg_addr == NIC_VEC_BASE + 8'(i))  reg_rdata = vec_q[i];
                end
            end
        endcase
    end

    // R3: only an enabled, pending source reaches the processor
    assert_enabled_only_R3: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (en_q[irq_id] && pend[irq_id]));

    // R7: a nested request is strictly more urgent in its preemption field
    assert_strict_nest_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !stk_empty) |-> ((prio_q[irq_id] & pmask) < (stk_top & pmask)));

endmodule

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
    localparam int N   = 16;
    localparam int DW  = 32;
    localparam int VB  = 32'h100;

    typedef struct packed {
        logic [15:0] pend;
        logic [15:0] en;
        logic        req;
        logic [3:0]  id;
    } vec_t;

    // Priorities used by the table: prio[i] = (i%4)*4 + i/4
    localparam vec_t TBL [10] = '{
        '{16'h0002, 16'hFFFF, 1'b1, 4'd1},
        '{16'h0012, 16'hFFFF, 1'b1, 4'd4},
        '{16'h0012, 16'h0002, 1'b1, 4'd1},
        '{16'h0012, 16'h0000, 1'b0, 4'd0},
        '{16'hF000, 16'hFFFF, 1'b1, 4'd12},
        '{16'h8888, 16'hFFFF, 1'b1, 4'd3},
        '{16'hFFFE, 16'hFFFE, 1'b1, 4'd4},
        '{16'hFFFF, 16'hEEEE, 1'b1, 4'd1},
        '{16'h4400, 16'hFFFF, 1'b1, 4'd10},
        '{16'h0000, 16'hFFFF, 1'b0, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_req;
    logic [3:0]    irq_id;
    logic [DW-1:0] irq_vec;
    logic          irq_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nest_irq_ctrl u_nest_irq_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_id(irq_id), .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk);
        irq_in = m;
        @(negedge clk);
        irq_in = '0;
        #1;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #1;
    endtask

    task automatic see(input string req, input logic r, input logic [3:0] id);
        chk(req, {31'd0, irq_req}, {31'd0, r});
        if (r) begin
            chk(req, {28'd0, irq_id}, {28'd0, id});
            chk(req, irq_vec, VB + 4 * id);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R9: reset state
        chk("R9 req", {31'd0, irq_req}, 32'd0);
        rd(8'h00, d); chk("R9 enable", d, 32'd0);
        rd(8'h01, d); chk("R9 pending", d, 32'd0);
        rd(8'h02, d); chk("R9 grouping", d, 32'd0);
        rd(8'h41, d); chk("R9 priority", d, 32'd0);
        rd(8'h04, d); chk("R10 empty level", d, 32'd0);
        rd(8'h85, d); chk("R5 reset vector", d, VB + 20);

        for (int i = 0; i < N; i++) wr(8'h40 + 8'(i), 32'((i % 4) * 4 + i / 4));

        // R3 and R4: table of arbitration patterns at idle
        for (int k = 0; k < 10; k++) begin
            wr(8'h01, 32'hFFFF);
            wr(8'h00, {16'd0, TBL[k].en});
            pulse(TBL[k].pend);
            see($sformatf("R3/R4 vector %0d", k), TBL[k].req, TBL[k].id);
        end
        wr(8'h01, 32'hFFFF);
        wr(8'h00, 32'hFFFF);

        // R1: edge, not level
        @(negedge clk); irq_in = 16'h0004;
        @(negedge clk); #1;
        rd(8'h01, d); chk("R1 set by edge", d, 32'h0004);
        wr(8'h01, 32'h0004);
        rd(8'h01, d); chk("R1 held line no reset", d, 32'h0000);
        irq_in = '0;

        // R2: write-one clear, zeros ignored, edge wins over clear
        pulse(16'h0030);
        rd(8'h01, d); chk("R1 latched after fall", d, 32'h0030);
        wr(8'h01, 32'h0010);
        rd(8'h01, d); chk("R2 clear one bit", d, 32'h0020);
        wr(8'h01, 32'h0000);
        rd(8'h01, d); chk("R2 zero write", d, 32'h0020);
        wr(8'h01, 32'hFFFF);
        @(negedge clk);
        irq_in = 16'h0040; reg_wr = 1'b1; reg_addr = 8'h01; reg_wdata = 32'h0040;
        @(negedge clk);
        reg_wr = 1'b0; irq_in = '0;
        rd(8'h01, d); chk("R2 edge beats clear", d, 32'h0040);
        wr(8'h01, 32'hFFFF);

        // R6, R7, R8: nesting with grouping 0
        pulse(16'h0008);
        see("R4 idle take", 1'b1, 4'd3);
        ack();
        rd(8'h04, d); chk("R10 level after push", d, 32'h0C01);
        see("R6 same level withheld", 1'b0, 4'd0);
        pulse(16'h0010);
        see("R7 more urgent nests", 1'b1, 4'd4);
        ack();
        rd(8'h04, d); chk("R10 depth two", d, 32'h0102);
        pulse(16'h0100);
        see("R6 less urgent withheld", 1'b0, 4'd0);
        wr(8'h03, 32'd0);
        rd(8'h04, d); chk("R8 pop level", d, 32'h0C01);
        see("R8 uncleared retaken", 1'b1, 4'd4);
        wr(8'h01, 32'h0010);
        see("R8 next pending", 1'b1, 4'd8);
        wr(8'h01, 32'h0108);
        see("R8 nothing left", 1'b0, 4'd0);
        wr(8'h03, 32'd0);
        rd(8'h04, d); chk("R8 back to idle", d, 32'h0000);

        // R7: grouping
        wr(8'h02, 32'd2);
        pulse(16'h8000);
        see("R4 idle take grouped", 1'b1, 4'd15);
        ack();
        pulse(16'h4000);
        see("R7 preempt field smaller", 1'b1, 4'd14);
        wr(8'h02, 32'd4);
        see("R7 no preempt bits", 1'b0, 4'd0);
        wr(8'h02, 32'd9);
        rd(8'h02, d); chk("R7 clamp", d, 32'd4);
        wr(8'h02, 32'd2);
        see("R7 regroup", 1'b1, 4'd14);
        wr(8'h01, 32'h4000);
        pulse(16'h0080);
        see("R7 equal field no nest", 1'b0, 4'd0);
        wr(8'h03, 32'd0);
        see("R8 idle arbitration", 1'b1, 4'd7);
        wr(8'h01, 32'hFFFF);

        // R4: tie on full priority goes to lower number
        wr(8'h46, 32'd6);
        pulse(16'h0240);
        see("R4 tie lower id", 1'b1, 4'd6);
        wr(8'h01, 32'hFFFF);
        pulse(16'h3100);
        see("R4 sub-ordering", 1'b1, 4'd8);

        // R5: programmed vector
        wr(8'h88, 32'hDEAD0000);
        chk("R5 programmed vector", irq_vec, 32'hDEAD0000);
        rd(8'h88, d); chk("R5 vector readback", d, 32'hDEAD0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule